// File: doc/BRIEF.md
# I/O Privilege Gate with Guarded Flag Loads

This block sits beside the execute stage of a protected-mode core. Each cycle it may receive one decoded instruction class together with the current privilege level. It may also receive a task-switch request.

For the small group of instructions that touch I/O ports, the interrupt-enable flag or the bus lock, the block compares the current privilege level with the I/O privilege field held in its own flag register. It then either grants the instruction or raises a one-cycle general-protection fault.

The block also owns the 16-bit flag word. Only three events may reload that word: a task switch, a pop-flags and an interrupt return. The block decides, from the current privilege level, which bits each of those events may change.

The I/O privilege field sits at bits 13:12 and the interrupt-enable flag at bit 9. Software cannot write the privilege field through any dedicated path. Below privilege 0, a pop-flags or an interrupt return leaves that field as it was and gives no sign of having done so.

Top module: `iopl_gate`

## Requirements
- R1: The restricted classes are codes 1 to 7 of `instr_class`, as follows:
  - 1: port in
  - 2: port out
  - 3: string in
  - 4: string out
  - 5: set interrupt-enable
  - 6: clear interrupt-enable
  - 7: bus lock

  Code 8 is pop-flags and code 9 is interrupt return. Every other code is an unrestricted instruction.
- R2: A valid restricted instruction with `cpl` numerically above the I/O privilege field drives `gp_fault` high for exactly the next cycle. In that cycle `fault_vec` reads 13; in all other cycles it reads 0.
- R3: A valid restricted instruction with `cpl` at or below the I/O privilege field pulses `exec_ok` in the next cycle and raises no fault. Unrestricted codes, pop-flags and interrupt return never fault and never pulse `exec_ok`.
- R4: A faulted instruction leaves the flag word unchanged.
- R5: Pop-flags at `cpl` 0 loads all 16 bits from `load_data`. At any other `cpl` it loads every bit except 13:12, which keep their value, and it raises no fault.
- R6: Interrupt return follows the same privilege rule as pop-flags.
- R7: `task_sw` loads all of `load_data` into the flag word at any `cpl`. In that cycle the instruction inputs are ignored, so there is no fault and no `exec_ok`.
- R8: A granted set or clear of interrupt-enable changes only bit 9, setting it or clearing it respectively.
- R9: In a cycle with no task switch and no valid flag-loading or interrupt-enable instruction, the flag word holds its value.
- R10: While `rst_n` is low, the flag word is zero and `gp_fault` and `exec_ok` are low.
- R11: `iopl` always equals bits 13:12 of `flags`. With the field at 3, every privilege level passes the check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr_class | input | 4 | Decoded instruction class code |
| cpl | input | 2 | Current privilege level |
| task_sw | input | 1 | Task switch: load the whole flag word |
| load_data | input | 16 | Flag image for task switch, pop-flags or interrupt return |
| flags | output | 16 | Flag register |
| iopl | output | 2 | I/O privilege field of the flag register |
| gp_fault | output | 1 | One-cycle general-protection fault pulse |
| fault_vec | output | 8 | Fault vector, 13 while `gp_fault` is high |
| exec_ok | output | 1 | One-cycle grant pulse for a restricted instruction |

## Verification
The bench builds the block with its default parameters: a 16-bit flag word, the privilege field at bit 12, interrupt-enable at bit 9 and vector 13. With these values, every field position the requirements name lines up with the bench's reference model.

The 2-bit privilege widths make all sixteen pairs of privilege level and I/O privilege field reachable. The directed steps cover the equal, above and below cases, and a random phase then covers these pairs and their combinations with task switches.

// File: rtl/iopl_pkg.sv
package iopl_pkg;

  typedef enum logic [3:0] {
    IC_OTHER = 4'd0,
    IC_IN    = 4'd1,
    IC_OUT   = 4'd2,
    IC_INS   = 4'd3,
    IC_OUTS  = 4'd4,
    IC_STI   = 4'd5,
    IC_CLI   = 4'd6,
    IC_LOCK  = 4'd7,
    IC_POPF  = 4'd8,
    IC_IRET  = 4'd9
  } instr_e;

  // R1: codes 1..7 are gated by the privilege check
  function automatic logic is_gated(input logic [3:0] code);
    return (code >= 4'd1) && (code <= 4'd7);
  endfunction

  function automatic logic is_flag_pop(input logic [3:0] code);
    return (code == IC_POPF) || (code == IC_IRET);
  endfunction

endpackage

// File: rtl/iopl_priv_check.sv
module iopl_priv_check
  import iopl_pkg::*;
#(
  parameter int PL_W = 2
) (
  input  logic            instr_valid,
  input  logic [3:0]      instr_class,
  input  logic            task_sw,
  input  logic [PL_W-1:0] cpl,
  input  logic [PL_W-1:0] iopl,
  output logic            deny,
  output logic            grant
);

  logic gated_live;

  always_comb begin
    gated_live = instr_valid && !task_sw && is_gated(instr_class);
    deny       = gated_live && (cpl > iopl);
    grant      = gated_live && !(cpl > iopl);
  end

endmodule

// File: rtl/iopl_flag_merge.sv
module iopl_flag_merge
  import iopl_pkg::*;
#(
  parameter int FLAG_W   = 16,
  parameter int PL_W     = 2,
  parameter int IOPL_LSB = 12,
  parameter int IE_BIT   = 9
) (
  input  logic              instr_valid,
  input  logic [3:0]        instr_class,
  input  logic              task_sw,
  input  logic [PL_W-1:0]   cpl,
  input  logic              grant,
  input  logic [FLAG_W-1:0] cur_flags,
  input  logic [FLAG_W-1:0] load_data,
  output logic              wr_en,
  output logic [FLAG_W-1:0] wr_data
);

  localparam logic [FLAG_W-1:0] PL_MASK =
    ((FLAG_W'(1) << PL_W) - FLAG_W'(1)) << IOPL_LSB;
  localparam logic [FLAG_W-1:0] IE_MASK = FLAG_W'(1) << IE_BIT;

  logic [FLAG_W-1:0] keep_mask;

  always_comb begin
    wr_en     = 1'b0;
    wr_data   = cur_flags;
    keep_mask = '0;
    if (task_sw) begin
      wr_en   = 1'b1;
      wr_data = load_data;
    end else if (instr_valid) begin
      if (is_flag_pop(instr_class)) begin
        keep_mask = (cpl == '0) ? '0 : PL_MASK;
        wr_en     = 1'b1;
        wr_data   = (load_data & ~keep_mask) | (cur_flags & keep_mask);
      end else if (grant && (instr_class == IC_STI)) begin
        wr_en   = 1'b1;
        wr_data = cur_flags | IE_MASK;
      end else if (grant && (instr_class == IC_CLI)) begin
        wr_en   = 1'b1;
        wr_data = cur_flags & ~IE_MASK;
      end
    end
  end

endmodule

// File: rtl/iopl_flag_reg.sv
module iopl_flag_reg #(
  parameter int FLAG_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_data,
  output logic [FLAG_W-1:0] q
);

  logic [FLAG_W-1:0] q_nxt;

  always_comb begin
    q_nxt = wr_en ? wr_data : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/iopl_gate.sv
module iopl_gate
  import iopl_pkg::*;
#(
  parameter int FLAG_W    = 16,
  parameter int PL_W      = 2,
  parameter int IOPL_LSB  = 12,
  parameter int IE_BIT    = 9,
  parameter int VEC_W     = 8,
  parameter int FAULT_VEC = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [3:0]        instr_class,
  input  logic [PL_W-1:0]   cpl,
  input  logic              task_sw,
  input  logic [FLAG_W-1:0] load_data,
  output logic [FLAG_W-1:0] flags,
  output logic [PL_W-1:0]   iopl,
  output logic              gp_fault,
  output logic [VEC_W-1:0]  fault_vec,
  output logic              exec_ok
);

  logic              deny, grant, wr_en;
  logic [FLAG_W-1:0] wr_data;
  logic              fault_nxt, ok_nxt;

  assign iopl = flags[IOPL_LSB +: PL_W];

  iopl_priv_check #(.PL_W(PL_W)) u_chk_pl (
    .instr_valid(instr_valid), .instr_class(instr_class), .task_sw(task_sw),
    .cpl(cpl), .iopl(iopl), .deny(deny), .grant(grant)
  );

  iopl_flag_merge #(
    .FLAG_W(FLAG_W), .PL_W(PL_W), .IOPL_LSB(IOPL_LSB), .IE_BIT(IE_BIT)
  ) u_merge (
    .instr_valid(instr_valid), .instr_class(instr_class), .task_sw(task_sw),
    .cpl(cpl), .grant(grant), .cur_flags(flags), .load_data(load_data),
    .wr_en(wr_en), .wr_data(wr_data)
  );

  iopl_flag_reg #(.FLAG_W(FLAG_W)) u_freg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .q(flags)
  );

  always_comb begin
    fault_nxt = deny;
    ok_nxt    = grant;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gp_fault <= 1'b0;
      exec_ok  <= 1'b0;
    end else begin
      gp_fault <= fault_nxt;
      exec_ok  <= ok_nxt;
    end
  end

  assign fault_vec = gp_fault ? VEC_W'(FAULT_VEC) : '0;

endmodule

// File: rtl/iopl_gate_chk.sv
module iopl_gate_chk #(
  parameter int FLAG_W    = 16,
  parameter int PL_W      = 2,
  parameter int IOPL_LSB  = 12,
  parameter int VEC_W     = 8,
  parameter int FAULT_VEC = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_valid,
  input logic [3:0]        instr_class,
  input logic [PL_W-1:0]   cpl,
  input logic              task_sw,
  input logic [FLAG_W-1:0] load_data,
  input logic [FLAG_W-1:0] flags,
  input logic              gp_fault,
  input logic [VEC_W-1:0]  fault_vec,
  input logic              exec_ok
);

  logic gated;
  assign gated = (instr_class >= 4'd1) && (instr_class <= 4'd7);

  p_fault_raised_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !task_sw && gated && (cpl > flags[IOPL_LSB +: PL_W]))
      |=> gp_fault);

  p_fault_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |-> (fault_vec == VEC_W'(FAULT_VEC)));

  p_fault_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(gp_fault && exec_ok));

  p_no_write_on_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |-> (flags == $past(flags)));

  p_pop_keeps_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !task_sw && (instr_class == 4'd8) && (cpl != '0))
      |=> (flags[IOPL_LSB +: PL_W] == $past(flags[IOPL_LSB +: PL_W])));

  p_task_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    task_sw |=> (flags == $past(load_data)) && !gp_fault && !exec_ok);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!task_sw && !instr_valid) |=> $stable(flags));

endmodule

bind iopl_gate iopl_gate_chk #(
  .FLAG_W(FLAG_W), .PL_W(PL_W), .IOPL_LSB(IOPL_LSB),
  .VEC_W(VEC_W), .FAULT_VEC(FAULT_VEC)
) u_bound_chk (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
  .instr_class(instr_class), .cpl(cpl), .task_sw(task_sw),
  .load_data(load_data), .flags(flags), .gp_fault(gp_fault),
  .fault_vec(fault_vec), .exec_ok(exec_ok)
);

// File: tb/sim_iopl_gate.sv
`timescale 1ns/1ps
module sim_iopl_gate;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid;
  logic [3:0]  instr_class;
  logic [1:0]  cpl;
  logic        task_sw;
  logic [15:0] load_data;
  logic [15:0] flags;
  logic [1:0]  iopl;
  logic        gp_fault;
  logic [7:0]  fault_vec;
  logic        exec_ok;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R10";

  // reference model state
  logic [15:0] m_flags;
  logic        m_fault, m_ok;

  always #2 clk = ~clk;

  iopl_gate u0 (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
    .instr_class(instr_class), .cpl(cpl), .task_sw(task_sw),
    .load_data(load_data), .flags(flags), .iopl(iopl),
    .gp_fault(gp_fault), .fault_vec(fault_vec), .exec_ok(exec_ok)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flags <= 16'h0;
      m_fault <= 1'b0;
      m_ok    <= 1'b0;
    end else begin
      m_fault <= 1'b0;
      m_ok    <= 1'b0;
      if (task_sw) begin
        m_flags <= load_data;
      end else if (instr_valid) begin
        if (instr_class >= 1 && instr_class <= 7) begin
          if (int'(cpl) > int'(m_flags[13:12])) begin
            m_fault <= 1'b1;
          end else begin
            m_ok <= 1'b1;
            if (instr_class == 5) m_flags[9] <= 1'b1;
            if (instr_class == 6) m_flags[9] <= 1'b0;
          end
        end else if (instr_class == 8 || instr_class == 9) begin
          if (cpl == 0) m_flags <= load_data;
          else m_flags <= {load_data[15:14], m_flags[13:12], load_data[11:0]};
        end
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(tag, "flags", flags, m_flags);
    chk(tag, "gp_fault", gp_fault, m_fault);
    chk(tag, "fault_vec", fault_vec, m_fault ? 13 : 0);
    chk(tag, "exec_ok", exec_ok, m_ok);
    chk("R11", "iopl", iopl, flags[13:12]);
  endtask

  task automatic step(input string t, input logic v, input int cls,
                      input int pl, input logic ts, input int d);
    instr_valid = v;
    instr_class = 4'(cls);
    cpl         = 2'(pl);
    task_sw     = ts;
    load_data   = 16'(d);
    @(posedge clk);
    @(negedge clk);
    tag = t;
    compare_all();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    instr_valid = 0; instr_class = 0; cpl = 0; task_sw = 0; load_data = 0;
    repeat (3) @(negedge clk);
    tag = "R10";
    compare_all();
    chk("R10", "flags in reset", flags, 0);
    rst_n = 1'b1;
    step("R7",  0, 0, 3, 1, 16'h3202);
    chk("R7", "task load", flags, 16'h3202);
    step("R11", 1, 1, 3, 0, 0);
    chk("R11", "pass at field 3", exec_ok, 1);
    step("R7",  0, 0, 3, 1, 16'h0000);
    step("R2",  1, 2, 3, 0, 0);
    chk("R2", "fault", gp_fault, 1);
    step("R4",  1, 5, 3, 0, 0);
    chk("R4", "faulted set-ie", flags, 16'h0000);
    step("R8",  1, 5, 0, 0, 0);
    chk("R8", "set-ie", flags, 16'h0200);
    step("R8",  1, 6, 0, 0, 16'hFFFF);
    chk("R8", "clear-ie", flags, 16'h0000);
    step("R3",  1, 0, 3, 0, 0);
    step("R3",  1, 10, 3, 0, 16'hFFFF);
    chk("R3", "unrestricted no fault", gp_fault, 0);
    step("R5",  1, 8, 0, 0, 16'h3ACF);
    chk("R5", "pop cpl0", flags, 16'h3ACF);
    step("R5",  1, 8, 2, 0, 16'h0055);
    chk("R5", "pop cpl2", flags, 16'h3055);
    step("R6",  1, 9, 1, 0, 16'h1FFF);
    chk("R6", "iret cpl1", flags, 16'h3FFF);
    step("R6",  1, 9, 0, 0, 16'h0123);
    chk("R6", "iret cpl0", flags, 16'h0123);
    step("R7",  1, 8, 2, 1, 16'h2200);
    chk("R7", "task wins", flags, 16'h2200);
    step("R1",  1, 7, 3, 0, 0);
    chk("R1", "lock gated", gp_fault, 1);
    step("R1",  1, 3, 1, 0, 0);
    step("R1",  1, 4, 3, 0, 0);
    step("R9",  0, 8, 0, 0, 16'hFFFF);
    chk("R9", "idle hold", flags, 16'h2200);
    for (int i = 0; i < 400; i++) begin
      step("R9", ($urandom % 4) != 0, $urandom % 12, $urandom % 4,
           ($urandom % 8) == 0, $urandom);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule